// File: doc/BRIEF.md
# 1-Wire Bit and Reset Slot Engine

This block drives an open-drain 1-Wire bus from a small command port. A host presents a command code with a parameter byte for one cycle; when the engine is idle it acknowledges and runs one operation. Commands that arrive while it is busy are dropped, as are unknown codes.

Two operations exist. The first is a reset cycle. The bus is held low, then released. The level at the release moment shows a short. A later sample shows whether a slave answered with a presence pulse. The second is a single time slot. It writes a zero or a one according to bit 7 of the parameter byte, and the slot's level at a fixed sample point is kept as the slot result. A write-one slot is therefore also a read slot.

All timing is counted in ticks of `CLK_PER_TICK` clocks. There are two timing sets, standard and overdrive. The speed and active-pullup settings are captured when a command is accepted. The bus is modelled as a drive-low enable plus a sampled input level. An active-pullup enable output pulses for one tick at each release edge.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset the status byte is 0, the bus is not driven low, and `cmd_ack` and `apu_en` are 0.
- R2: A command with code 8'h87 (bit slot) or 8'hB4 (reset cycle) presented while idle is acknowledged by a one-cycle `cmd_ack` in the next cycle. Status bit 0 (busy) goes to 1 at the same time.
- R3: A command presented while busy, or any other code, is not acknowledged. It causes no bus activity and does not change the timing of an operation already in progress.
- R4: In a bit slot, parameter bit 7 (V) selects the low time: LOW0 ticks for V=0 and LOW1 ticks for V=1. Parameter bits 6..0 have no effect. Busy stays set for SLOT ticks plus one clock.
- R5: In a bit slot, status bit 5 is loaded with the bus level sampled MSR ticks after the slot starts. A reset cycle leaves it unchanged.
- R6: A reset cycle drives the bus low for RSTL ticks. Busy stays set for RSTL+RSTH ticks plus one clock.
- R7: A reset cycle first clears status bits 1 and 2. Bit 2 (short) is set if the bus is still low at the release moment. Bit 1 (presence) is set if the bus is low MSP ticks after release and no short was seen. A bit slot leaves both bits unchanged.
- R8: When `cfg_od` is 1 at acceptance, the overdrive timing set is used for every interval of that operation.
- R9: When `cfg_apu` is 1 at acceptance, `apu_en` is high for exactly one tick, starting at the release edge. It is never high while the bus is driven low, and it stays 0 when `cfg_apu` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command code |
| cmd_param | input | 8 | Parameter byte; bit 7 is V |
| cfg_od | input | 1 | Overdrive timing select |
| cfg_apu | input | 1 | Active-pullup enable select |
| line_in | input | 1 | Sampled bus level |
| cmd_ack | output | 1 | Command accepted pulse |
| line_pull_low | output | 1 | Drive bus low when 1 |
| apu_en | output | 1 | Active-pullup pulse at release |
| status | output | 8 | bit0 busy, bit1 presence, bit2 short, bit5 slot result |

## Verification
A wrong internal state would show at the ports as a slot or reset whose low time or busy length is off by whole ticks. Such an error is seen at the end of that same operation. A corrupted sampling point would show up as a wrong presence, short or slot-result bit once busy clears. The bench uses slave models whose pulls cover the sample point on one side and end before it on the other, so a misplaced sample flips the result. A lost busy guard would show at once as an acknowledge during an active operation, or as a stretched busy time.

// File: rtl/owire_slot_engine.sv
module owire_slot_engine #(
  parameter int CLK_PER_TICK = 100,
  parameter logic [7:0] BIT_CODE = 8'h87,
  parameter logic [7:0] RST_CODE = 8'hB4,
  parameter int STD_RSTL = 560,
  parameter int STD_MSP  = 68,
  parameter int STD_RSTH = 560,
  parameter int STD_SLOT = 70,
  parameter int STD_LOW0 = 60,
  parameter int STD_LOW1 = 6,
  parameter int STD_MSR  = 10,
  parameter int OD_RSTL  = 70,
  parameter int OD_MSP   = 8,
  parameter int OD_RSTH  = 70,
  parameter int OD_SLOT  = 10,
  parameter int OD_LOW0  = 8,
  parameter int OD_LOW1  = 1,
  parameter int OD_MSR   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic [7:0] cmd_param,
  input  logic       cfg_od,
  input  logic       cfg_apu,
  input  logic       line_in,
  output logic       cmd_ack,
  output logic       line_pull_low,
  output logic       apu_en,
  output logic [7:0] status
);
  localparam int CW = $clog2(STD_RSTL + STD_RSTH + OD_RSTL + OD_RSTH + 2) + 1;
  localparam int PW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;

  typedef enum logic [1:0] {IDLE, RST_CYC, BIT_SLOT} state_t;

  state_t st;
  logic [CW-1:0] cnt, t_low, t_smp, t_end;
  logic [PW-1:0] pre;
  logic od_q, apu_q, v_q, pres_q, short_q, sbr_q, ack_q;
  logic unused_param;

  wire busy     = (st != IDLE);
  wire at_start = (pre == '0);
  wire is_known = (cmd_code == BIT_CODE) || (cmd_code == RST_CODE);
  wire accept   = cmd_valid && !busy && is_known;

  assign unused_param = ^cmd_param[6:0];

  always_comb begin
    if (st == RST_CYC) begin
      t_low = od_q ? CW'(OD_RSTL) : CW'(STD_RSTL);
      t_smp = t_low + (od_q ? CW'(OD_MSP) : CW'(STD_MSP));
      t_end = t_low + (od_q ? CW'(OD_RSTH) : CW'(STD_RSTH));
    end else begin
      if (v_q) t_low = od_q ? CW'(OD_LOW1) : CW'(STD_LOW1);
      else     t_low = od_q ? CW'(OD_LOW0) : CW'(STD_LOW0);
      t_smp = od_q ? CW'(OD_MSR)  : CW'(STD_MSR);
      t_end = od_q ? CW'(OD_SLOT) : CW'(STD_SLOT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      pre     <= '0;
      od_q    <= 1'b0;
      apu_q   <= 1'b0;
      v_q     <= 1'b0;
      pres_q  <= 1'b0;
      short_q <= 1'b0;
      sbr_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= accept;
      if (accept) begin
        st    <= (cmd_code == RST_CODE) ? RST_CYC : BIT_SLOT;
        cnt   <= '0;
        pre   <= '0;
        od_q  <= cfg_od;
        apu_q <= cfg_apu;
        v_q   <= cmd_param[7];
        if (cmd_code == RST_CODE) begin
          pres_q  <= 1'b0;
          short_q <= 1'b0;
        end
      end else if (busy) begin
        if (pre == PW'(CLK_PER_TICK - 1)) begin
          pre <= '0;
          cnt <= cnt + 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
        if (at_start && st == RST_CYC && cnt == t_low)
          short_q <= !line_in;
        if (at_start && cnt == t_smp) begin
          if (st == RST_CYC) pres_q <= !line_in && !short_q;
          else               sbr_q  <= line_in;
        end
        if (at_start && cnt == t_end)
          st <= IDLE;
      end
    end
  end

  assign cmd_ack       = ack_q;
  assign line_pull_low = busy && (cnt < t_low);
  assign apu_en        = busy && apu_q && (cnt == t_low);
  assign status        = {2'b00, sbr_q, 2'b00, short_q, pres_q, busy};
endmodule

// File: rtl/owire_slot_engine_chk.sv
module owire_slot_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ack,
  input logic       line_pull_low,
  input logic       apu_en,
  input logic [7:0] status
);
  assert_ack_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> status[0]);

  assert_no_ack_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && status[0]) |=> !cmd_ack);

  assert_pull_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull_low |-> status[0]);

  assert_short_excl_presence_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]));

  assert_apu_not_with_pull_R9: assert property (@(posedge clk) disable iff (!rst_n)
    apu_en |-> !line_pull_low);

  assert_released_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !line_pull_low);
endmodule

bind owire_slot_engine owire_slot_engine_chk u_chk (.*);

// File: tb/owire_slot_engine_bench.sv
`timescale 1ns/1ps
module owire_slot_engine_bench;
  localparam int P = 2;
  localparam int S_RSTL = 560, S_MSP = 68, S_RSTH = 560, S_SLOT = 70, S_LOW0 = 60, S_LOW1 = 6, S_MSR = 10;
  localparam int O_RSTL = 70, O_MSP = 8, O_RSTH = 70, O_SLOT = 10, O_LOW0 = 8, O_LOW1 = 1, O_MSR = 2;

  logic clk = 0, rst_n = 0, cmd_valid = 0, cfg_od = 0, cfg_apu = 0;
  logic [7:0] cmd_code = 0, cmd_param = 0;
  logic line_in, cmd_ack, line_pull_low, apu_en;
  logic [7:0] status;
  int checks = 0, fails = 0;
  int smode = 0;
  int rel_t = 100000, rise_t = 100000;
  logic prev_pull = 0, slave_low;
  bit e_pres = 0, e_short = 0, e_sbr = 0;

  always #2.5 clk = ~clk;

  owire_slot_engine #(
    .CLK_PER_TICK(P),
    .STD_RSTL(S_RSTL), .STD_MSP(S_MSP), .STD_RSTH(S_RSTH), .STD_SLOT(S_SLOT),
    .STD_LOW0(S_LOW0), .STD_LOW1(S_LOW1), .STD_MSR(S_MSR),
    .OD_RSTL(O_RSTL), .OD_MSP(O_MSP), .OD_RSTH(O_RSTH), .OD_SLOT(O_SLOT),
    .OD_LOW0(O_LOW0), .OD_LOW1(O_LOW1), .OD_MSR(O_MSR)
  ) u_owire_slot_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_param(cmd_param), .cfg_od(cfg_od), .cfg_apu(cfg_apu), .line_in(line_in),
    .cmd_ack(cmd_ack), .line_pull_low(line_pull_low), .apu_en(apu_en), .status(status)
  );

  // slave model: 1 short, 2 presence after release, 3 hold low from slot start
  always @(posedge clk) begin
    prev_pull <= line_pull_low;
    if (!prev_pull && line_pull_low) rise_t <= 0; else if (rise_t < 100000) rise_t <= rise_t + 1;
    if (prev_pull && !line_pull_low) rel_t <= 0;  else if (rel_t < 100000)  rel_t <= rel_t + 1;
  end

  always_comb begin
    case (smode)
      1: slave_low = 1'b1;
      2: slave_low = cfg_od ? (rel_t >= 4 && rel_t < 28) : (rel_t >= 30 && rel_t < 230);
      3: slave_low = cfg_od ? (rise_t < 8) : (rise_t < 40);
      default: slave_low = 1'b0;
    endcase
  end
  assign line_in = !(line_pull_low || slave_low);

  function automatic int exp_low(bit is_rst, bit od, bit v);
    if (is_rst) return (od ? O_RSTL : S_RSTL) * P;
    if (v) return (od ? O_LOW1 : S_LOW1) * P;
    return (od ? O_LOW0 : S_LOW0) * P;
  endfunction

  function automatic int exp_busy(bit is_rst, bit od);
    if (is_rst) return (od ? O_RSTL + O_RSTH : S_RSTL + S_RSTH) * P + 1;
    return (od ? O_SLOT : S_SLOT) * P + 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(bit is_rst, logic [7:0] prm, bit od, bit apu, int mode, bit inject);
    int busy_n = 0, low_n = 0, apu_n = 0, guard = 0, it = 0;
    bit v = prm[7];
    @(negedge clk);
    smode = mode; cfg_od = od; cfg_apu = apu;
    cmd_code = is_rst ? 8'hB4 : 8'h87; cmd_param = prm; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ack == 1, "R2 ack", int'(cmd_ack), 1);
    chk(status[0] == 1, "R2 busy", int'(status[0]), 1);
    while (status[0] && guard < 5000) begin
      busy_n++;
      if (line_pull_low) low_n++;
      if (apu_en) apu_n++;
      @(negedge clk);
      it++; guard++;
      if (inject && it == 3) begin
        cmd_code = 8'h87; cmd_param = 8'h80; cmd_valid = 1;
      end
      if (inject && it == 4) begin
        cmd_valid = 0;
        chk(cmd_ack == 0, "R3 busy reject", int'(cmd_ack), 0);
      end
    end
    if (is_rst) begin
      e_short = (mode == 1);
      e_pres = (mode == 2);
    end else begin
      e_sbr = v && (mode == 0);
    end
    chk(low_n == exp_low(is_rst, od, v), is_rst ? (od ? "R8 R6 low" : "R6 low") : (od ? "R8 R4 low" : "R4 low"),
        low_n, exp_low(is_rst, od, v));
    chk(busy_n == exp_busy(is_rst, od), is_rst ? "R6 R3 busy len" : "R4 R3 busy len",
        busy_n, exp_busy(is_rst, od));
    chk(apu_n == (apu ? P : 0), "R9 apu pulse", apu_n, apu ? P : 0);
    chk(status[1] == e_pres, "R7 presence", int'(status[1]), int'(e_pres));
    chk(status[2] == e_short, "R7 short", int'(status[2]), int'(e_short));
    chk(status[5] == e_sbr, "R5 slot result", int'(status[5]), int'(e_sbr));
    smode = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'hC0FFEE);
    repeat (4) @(negedge clk);
    chk(status == 8'h00, "R1 status", int'(status), 0);
    chk(line_pull_low == 0, "R1 pull", int'(line_pull_low), 0);
    chk(cmd_ack == 0 && apu_en == 0, "R1 ack/apu", int'({cmd_ack, apu_en}), 0);
    rst_n = 1;
    @(negedge clk);

    cmd_code = 8'h55; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ack == 0, "R3 unknown code ack", int'(cmd_ack), 0);
    chk(status[0] == 0 && line_pull_low == 0, "R3 unknown code idle", int'(status[0]), 0);

    run_op(1, 8'h00, 0, 0, 2, 1);
    run_op(1, 8'h00, 0, 1, 1, 0);
    run_op(1, 8'h00, 1, 0, 0, 0);
    run_op(1, 8'h00, 1, 1, 2, 0);
    run_op(0, 8'h80, 0, 0, 0, 1);
    run_op(0, 8'h7F, 0, 1, 0, 0);
    run_op(0, 8'hFF, 0, 0, 3, 0);
    run_op(0, 8'h80, 1, 1, 0, 0);
    run_op(0, 8'h80, 1, 0, 3, 0);
    run_op(0, 8'h3C, 1, 0, 0, 0);

    for (int i = 0; i < 30; i++) begin
      bit is_rst = $urandom_range(0, 3) == 0;
      logic [7:0] prm = 8'($urandom);
      bit od = $urandom_range(0, 1) == 1;
      bit apu = $urandom_range(0, 1) == 1;
      int mode = $urandom_range(0, 2);
      if (!is_rst && mode == 2) mode = 3;
      run_op(is_rst, prm, od, apu, mode, $urandom_range(0, 4) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule